// File: doc/BRIEF.md
# JTAG Instruction Decoder and TDO Router

This block keeps the 4-bit instruction register of a test access port and turns the current instruction into routing and mode controls. The TAP controller state arrives as a 4-bit input. From that state, TCK and TDI, the block captures, shifts and updates the instruction. It then chooses which data register feeds the serial output: its own 1-bit bypass register, its own 32-bit identification register, the scan chain currently addressed by the chain-number input, or the external scan-path select register. It retimes the serial output on the falling edge of TCK.

Besides routing, the decoded instruction drives the system-side controls. These are scan cells in test mode, bus float with an external float indication, output clamp, forced-inactive tri-state enables, and a one-cycle processor restart pulse. The pulse fires when the TAP reaches Run-Test-Idle while the restart instruction is current. The TAP state machine, the scan chains and the scan-path select register are separate neighbours.

Top module: `jtag_ir_router`

## Requirements
- R1: The instruction codes are EXTEST 0000, SEL_CHAIN 0010, SAMPLE 0011, RESUME 0100, CLAMP 0101, HIGHZ 0111, CLAMP_OFF 1001, INTEST 1100, IDCODE 1110 and BYPASS 1111. Each one drives the routing and mode outputs listed in R4 to R10.
- R2: The codes 0001, 0110, 1000, 1010, 1011 and 1101 act exactly as BYPASS on every output.
- R3: In Capture-IR the instruction shift stage loads 0001. In Shift-IR it shifts right, with TDI entering at bit 3 and bit 0 presented on TDO. The current instruction changes only in Update-IR, which takes the shift stage, or in Test-Logic-Reset, which loads IDCODE. Asynchronous reset also loads IDCODE.
- R4: Under RESUME, CLAMP, HIGHZ, CLAMP_OFF, BYPASS and the unused codes, the bypass register is routed to TDO. It loads 0 in Capture-DR and passes TDI through with one TCK of delay in Shift-DR, so the first bit out is 0.
- R5: Under IDCODE the 32-bit ID register is routed. It loads ID_VALUE in Capture-DR and shifts it out LSB first in Shift-DR.
- R6: Under EXTEST and INTEST the scan chain picked by chain_sel_i is routed and test_mode_o is high. Under SAMPLE the same chain is routed with test_mode_o low. sel_chain_o is high for exactly these three instructions.
- R7: Under SEL_CHAIN, scanpath_tdo_i is routed to TDO and sel_scanpath_o is high.
- R8: float_bus_o and highz_o are high only under HIGHZ.
- R9: clamp_o is high under CLAMP and CLAMP_OFF. outs_off_o is high only under CLAMP_OFF.
- R10: restart_o pulses high for one cycle when the TAP state enters Run-Test-Idle while RESUME is current. It stays low under every other instruction and while the TAP remains in Run-Test-Idle.
- R11: tdo_o and tdo_en_o update on the falling edge of TCK. tdo_en_o is high only after a falling edge in Shift-IR or Shift-DR, and tdo_o is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tap_state_i | input | 4 | TAP controller state (encoding in package) |
| tdi_i | input | 1 | Serial test data in |
| chain_sel_i | input | SEL_W | Number of the currently selected scan chain |
| chain_tdo_i | input | 2**SEL_W | Serial outputs of all scan chains |
| scanpath_tdo_i | input | 1 | Serial output of the scan-path select register |
| tdo_o | output | 1 | Serial test data out, falling-edge timed |
| tdo_en_o | output | 1 | TDO drive enable |
| sel_chain_o | output | 1 | Selected scan chain is the active data register |
| sel_scanpath_o | output | 1 | Scan-path select register is the active data register |
| test_mode_o | output | 1 | Scan cells in test mode |
| float_bus_o | output | 1 | Float bus outputs |
| highz_o | output | 1 | External float indication |
| clamp_o | output | 1 | Scan cells drive the outputs from held data |
| outs_off_o | output | 1 | All tri-state outputs forced inactive |
| restart_o | output | 1 | One-cycle processor restart pulse |

## Verification
A corrupted instruction register appears at once on the mode outputs. It also shows on the next Shift-DR as the wrong bit pair at TDO, because the bypass, ID, chain and scan-path paths are stimulated so that each gives a different first two bits. A bad capture value shows on the first falling edge of Shift-IR or Shift-DR. A bypass that skips its delay stage makes the second shifted bit wrong. A mis-timed or repeated restart shows in the Run-Test-Idle cycle itself or in the cycle after it.

// File: rtl/jtag_ird_pkg.sv
package jtag_ird_pkg;

  typedef enum logic [3:0] {
    TS_EXIT2_DR   = 4'h0,
    TS_EXIT1_DR   = 4'h1,
    TS_SHIFT_DR   = 4'h2,
    TS_PAUSE_DR   = 4'h3,
    TS_SEL_IR     = 4'h4,
    TS_UPDATE_DR  = 4'h5,
    TS_CAPTURE_DR = 4'h6,
    TS_SEL_DR     = 4'h7,
    TS_EXIT2_IR   = 4'h8,
    TS_EXIT1_IR   = 4'h9,
    TS_SHIFT_IR   = 4'hA,
    TS_PAUSE_IR   = 4'hB,
    TS_IDLE       = 4'hC,
    TS_UPDATE_IR  = 4'hD,
    TS_CAPTURE_IR = 4'hE,
    TS_RESET      = 4'hF
  } tap_state_e;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] I_EXTEST    = 4'b0000;
  localparam logic [IR_W-1:0] I_SELCHAIN  = 4'b0010;
  localparam logic [IR_W-1:0] I_SAMPLE    = 4'b0011;
  localparam logic [IR_W-1:0] I_RESUME    = 4'b0100;
  localparam logic [IR_W-1:0] I_CLAMP     = 4'b0101;
  localparam logic [IR_W-1:0] I_HIGHZ     = 4'b0111;
  localparam logic [IR_W-1:0] I_CLAMPOFF  = 4'b1001;
  localparam logic [IR_W-1:0] I_INTEST    = 4'b1100;
  localparam logic [IR_W-1:0] I_IDCODE    = 4'b1110;
  localparam logic [IR_W-1:0] I_BYPASS    = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;

  typedef enum logic [1:0] {
    DR_BYP      = 2'd0,
    DR_ID       = 2'd1,
    DR_CHAIN    = 2'd2,
    DR_SCANPATH = 2'd3
  } dr_sel_e;

  typedef struct packed {
    dr_sel_e dr;
    logic    test_mode;
    logic    float_bus;
    logic    clamp;
    logic    outs_off;
    logic    resume;
  } decode_t;

  function automatic decode_t decode_ir(logic [IR_W-1:0] code);
    decode_t d;
    d = '{dr: DR_BYP, test_mode: 1'b0, float_bus: 1'b0, clamp: 1'b0,
          outs_off: 1'b0, resume: 1'b0};
    case (code)
      I_EXTEST, I_INTEST: begin d.dr = DR_CHAIN; d.test_mode = 1'b1; end
      I_SAMPLE:           d.dr = DR_CHAIN;
      I_SELCHAIN:         d.dr = DR_SCANPATH;
      I_IDCODE:           d.dr = DR_ID;
      I_RESUME:           d.resume = 1'b1;
      I_CLAMP:            d.clamp = 1'b1;
      I_HIGHZ:            d.float_bus = 1'b1;
      I_CLAMPOFF:         begin d.clamp = 1'b1; d.outs_off = 1'b1; end
      default:            ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/jtag_ir.sv
module jtag_ir
  import jtag_ird_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_o,
  output logic            ir_tdo_o
);

  logic [IR_W-1:0] sh_q;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= IR_CAPTURE;
      ir_q <= I_IDCODE;
    end else begin
      case (state_i)
        TS_CAPTURE_IR: sh_q <= IR_CAPTURE;
        TS_SHIFT_IR:   sh_q <= {tdi_i, sh_q[IR_W-1:1]};
        default:       ;
      endcase
      if (state_i == TS_RESET)          ir_q <= I_IDCODE;
      else if (state_i == TS_UPDATE_IR) ir_q <= sh_q;
    end
  end

  assign ir_o     = ir_q;
  assign ir_tdo_o = sh_q[0];

  a_r3_capture_pattern: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == TS_CAPTURE_IR |=> sh_q == IR_CAPTURE);
  a_r3_reset_idcode: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == TS_RESET |=> ir_q == I_IDCODE);
  a_r3_ir_holds: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i != TS_UPDATE_IR && state_i != TS_RESET) |=> $stable(ir_q));
  a_r3_update_takes_shift: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == TS_UPDATE_IR |=> ir_q == $past(sh_q));

endmodule

// File: rtl/jtag_dr_fixed.sv
module jtag_dr_fixed
  import jtag_ird_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0A5C_3E2D
) (
  input  logic       tck_i,
  input  logic       rst_ni,
  input  tap_state_e state_i,
  input  logic       tdi_i,
  input  dr_sel_e    dr_i,
  output logic       byp_tdo_o,
  output logic       id_tdo_o
);

  logic            byp_q;
  logic [ID_W-1:0] id_q;
  logic            byp_act, id_act;

  assign byp_act = (dr_i == DR_BYP);
  assign id_act  = (dr_i == DR_ID);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q <= 1'b0;
    end else if (byp_act) begin
      if (state_i == TS_CAPTURE_DR)    byp_q <= 1'b0;
      else if (state_i == TS_SHIFT_DR) byp_q <= tdi_i;
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q <= ID_VALUE;
    end else if (id_act) begin
      if (state_i == TS_CAPTURE_DR)    id_q <= ID_VALUE;
      else if (state_i == TS_SHIFT_DR) id_q <= {tdi_i, id_q[ID_W-1:1]};
    end
  end

  assign byp_tdo_o = byp_q;
  assign id_tdo_o  = id_q[0];

  a_r4_bypass_capture_zero: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == TS_CAPTURE_DR && byp_act) |=> !byp_q);
  a_r4_bypass_one_delay: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == TS_SHIFT_DR && byp_act) |=> byp_q == $past(tdi_i));
  a_r4_bypass_update_keeps: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == TS_UPDATE_DR) |=> $stable(byp_q));
  a_r5_id_capture: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == TS_CAPTURE_DR && id_act) |=> id_q == ID_VALUE);

endmodule

// File: rtl/jtag_tdo_out.sv
module jtag_tdo_out
  import jtag_ird_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  tap_state_e state_i,
  input  dr_sel_e    dr_i,
  input  logic       ir_tdo_i,
  input  logic       byp_tdo_i,
  input  logic       id_tdo_i,
  input  logic       chain_tdo_i,
  input  logic       scanpath_tdo_i,
  output logic       tdo_o,
  output logic       tdo_en_o
);

  logic dr_bit, nxt_bit, shifting;
  logic tdo_q, en_q;

  always_comb begin
    case (dr_i)
      DR_ID:       dr_bit = id_tdo_i;
      DR_CHAIN:    dr_bit = chain_tdo_i;
      DR_SCANPATH: dr_bit = scanpath_tdo_i;
      default:     dr_bit = byp_tdo_i;
    endcase
  end

  assign shifting = (state_i == TS_SHIFT_IR) || (state_i == TS_SHIFT_DR);
  assign nxt_bit  = (state_i == TS_SHIFT_IR) ? ir_tdo_i
                  : (state_i == TS_SHIFT_DR) ? dr_bit : 1'b0;

  // falling-edge retiming of the serial output
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      tdo_q <= nxt_bit;
      en_q  <= shifting;
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_en_o = en_q;

  a_r11_idle_no_drive: assert property (@(negedge tck_i) disable iff (!rst_ni)
    !shifting |=> (!tdo_en_o && !tdo_o));
  a_r11_shift_drives: assert property (@(negedge tck_i) disable iff (!rst_ni)
    shifting |=> tdo_en_o);
  a_r3_ir_bit_out: assert property (@(negedge tck_i) disable iff (!rst_ni)
    state_i == TS_SHIFT_IR |=> tdo_o == $past(ir_tdo_i));

endmodule

// File: rtl/jtag_ir_router.sv
module jtag_ir_router
  import jtag_ird_pkg::*;
#(
  parameter int              SEL_W    = 4,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0A5C_3E2D,
  localparam int             NCHAIN   = 1 << SEL_W
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic [3:0]        tap_state_i,
  input  logic              tdi_i,
  input  logic [SEL_W-1:0]  chain_sel_i,
  input  logic [NCHAIN-1:0] chain_tdo_i,
  input  logic              scanpath_tdo_i,
  output logic              tdo_o,
  output logic              tdo_en_o,
  output logic              sel_chain_o,
  output logic              sel_scanpath_o,
  output logic              test_mode_o,
  output logic              float_bus_o,
  output logic              highz_o,
  output logic              clamp_o,
  output logic              outs_off_o,
  output logic              restart_o
);

  tap_state_e      st, prev_q;
  logic [IR_W-1:0] ir;
  logic            ir_tdo, byp_tdo, id_tdo, chain_bit;
  decode_t         dec;

  assign st = tap_state_e'(tap_state_i);

  jtag_ir u_ir (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .state_i  (st),
    .tdi_i    (tdi_i),
    .ir_o     (ir),
    .ir_tdo_o (ir_tdo)
  );

  assign dec = decode_ir(ir);

  jtag_dr_fixed #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .state_i   (st),
    .tdi_i     (tdi_i),
    .dr_i      (dec.dr),
    .byp_tdo_o (byp_tdo),
    .id_tdo_o  (id_tdo)
  );

  assign chain_bit = chain_tdo_i[chain_sel_i];

  jtag_tdo_out u_out (
    .tck_i          (tck_i),
    .rst_ni         (rst_ni),
    .state_i        (st),
    .dr_i           (dec.dr),
    .ir_tdo_i       (ir_tdo),
    .byp_tdo_i      (byp_tdo),
    .id_tdo_i       (id_tdo),
    .chain_tdo_i    (chain_bit),
    .scanpath_tdo_i (scanpath_tdo_i),
    .tdo_o          (tdo_o),
    .tdo_en_o       (tdo_en_o)
  );

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= TS_RESET;
    else         prev_q <= st;
  end

  // pulse on the first Run-Test-Idle cycle only
  assign restart_o      = dec.resume && (st == TS_IDLE) && (prev_q != TS_IDLE);
  assign sel_chain_o    = (dec.dr == DR_CHAIN);
  assign sel_scanpath_o = (dec.dr == DR_SCANPATH);
  assign test_mode_o    = dec.test_mode;
  assign float_bus_o    = dec.float_bus;
  assign highz_o        = dec.float_bus;
  assign clamp_o        = dec.clamp;
  assign outs_off_o     = dec.outs_off;

  a_r10_restart_single: assert property (@(posedge tck_i) disable iff (!rst_ni)
    restart_o |=> !restart_o);
  a_r10_restart_in_idle: assert property (@(posedge tck_i) disable iff (!rst_ni)
    restart_o |-> (tap_state_i == 4'hC));
  a_r8_modes_exclusive: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0({test_mode_o, float_bus_o, clamp_o, sel_scanpath_o}));
  a_r9_off_implies_clamp: assert property (@(posedge tck_i) disable iff (!rst_ni)
    outs_off_o |-> clamp_o);

endmodule

// File: tb/jtag_ir_router_tb.sv
module jtag_ir_router_tb;
  import jtag_ird_pkg::*;

  localparam int          SEL_W = 4;
  localparam int          NCH   = 1 << SEL_W;
  localparam logic [31:0] IDV   = 32'h0A5C_3E2D;

  logic tck = 1'b0;
  always #4 tck = ~tck;

  logic             rst_n = 1'b0;
  logic [3:0]       tap_state = 4'hF;
  logic             tdi = 1'b0;
  logic [SEL_W-1:0] chain_sel = '0;
  logic [NCH-1:0]   chain_tdo = '0;
  logic             scanpath_tdo = 1'b0;
  logic tdo_o, tdo_en_o, sel_chain_o, sel_scanpath_o, test_mode_o;
  logic float_bus_o, highz_o, clamp_o, outs_off_o, restart_o;

  jtag_ir_router #(.SEL_W(SEL_W), .ID_W(32), .ID_VALUE(IDV)) u_dut (
    .tck_i(tck), .rst_ni(rst_n), .tap_state_i(tap_state), .tdi_i(tdi),
    .chain_sel_i(chain_sel), .chain_tdo_i(chain_tdo), .scanpath_tdo_i(scanpath_tdo),
    .tdo_o(tdo_o), .tdo_en_o(tdo_en_o), .sel_chain_o(sel_chain_o),
    .sel_scanpath_o(sel_scanpath_o), .test_mode_o(test_mode_o),
    .float_bus_o(float_bus_o), .highz_o(highz_o), .clamp_o(clamp_o),
    .outs_off_o(outs_off_o), .restart_o(restart_o)
  );

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  logic s_tdo, s_en, s_rst;
  logic [63:0] dr_out;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] st, input logic t);
    tap_state = st;
    tdi = t;
    @(negedge tck); #1;
    s_tdo = tdo_o; s_en = tdo_en_o; s_rst = restart_o;
    @(posedge tck); #1;
  endtask

  task automatic load_ir(input logic [3:0] code);
    step(TS_SEL_DR, 0);
    step(TS_SEL_IR, 0);
    step(TS_CAPTURE_IR, 0);
    for (int i = 0; i < 4; i++) begin
      step(TS_SHIFT_IR, code[i]);
      chk(s_tdo == (i == 0), "R3 capture bit", s_tdo, (i == 0));
      chk(s_en == 1'b1, "R11 enable in Shift-IR", s_en, 1);
    end
    step(TS_EXIT1_IR, 0);
    step(TS_UPDATE_IR, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din);
    step(TS_SEL_DR, 0);
    step(TS_CAPTURE_DR, 0);
    dr_out = '0;
    for (int i = 0; i < n; i++) begin
      step(TS_SHIFT_DR, din[i]);
      dr_out[i] = s_tdo;
    end
    step(TS_EXIT1_DR, 0);
    chk(s_en == 1'b0 && s_tdo == 1'b0, "R11 idle after shift", {s_en, s_tdo}, 0);
    step(TS_UPDATE_DR, 0);
  endtask

  // {route[1:0], test, float, clamp, off, resume}; route 0 byp,1 id,2 chain,3 scanpath
  function automatic logic [6:0] expect_mode(input logic [3:0] c);
    case (c)
      4'b0000, 4'b1100: return 7'b10_1000_0;
      4'b0011:          return 7'b10_0000_0;
      4'b0010:          return 7'b11_0000_0;
      4'b1110:          return 7'b01_0000_0;
      4'b0100:          return 7'b00_0000_1;
      4'b0101:          return 7'b00_0010_0;
      4'b0111:          return 7'b00_0100_0;
      4'b1001:          return 7'b00_0011_0;
      default:          return 7'b00_0000_0;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [6:0] em;
    logic [1:0] pair, exp_pair;
    repeat (3) @(posedge tck);
    #1 rst_n = 1'b1;
    #1;
    chk({test_mode_o, float_bus_o, highz_o, clamp_o, outs_off_o, restart_o} == 0,
        "R3 reset modes idle", {test_mode_o, float_bus_o, clamp_o}, 0);
    chk(tdo_o == 0 && tdo_en_o == 0, "R11 reset tdo", {tdo_en_o, tdo_o}, 0);
    step(TS_IDLE, 0);
    // R5: IDCODE selected after reset
    scan_dr(32, 64'hFFFF_FFFF);
    chk(dr_out[31:0] == IDV, "R5 ID after reset", dr_out[31:0], IDV);

    // R1 R2 R4 R5 R6 R7 R8 R9 R10: sweep all codes
    for (int c = 0; c < 16; c++) begin
      load_ir(c[3:0]);
      em = expect_mode(c[3:0]);
      chk({sel_chain_o, sel_scanpath_o} == {em[6] & ~em[5], em[6] & em[5]},
          "R1 R6 R7 select flags", {sel_chain_o, sel_scanpath_o}, em[6:5]);
      chk(test_mode_o == em[4], "R6 test mode", test_mode_o, em[4]);
      chk(float_bus_o == em[3] && highz_o == em[3], "R8 float", {float_bus_o, highz_o}, em[3]);
      chk(clamp_o == em[2] && outs_off_o == em[1], "R9 clamp", {clamp_o, outs_off_o}, em[2:1]);
      chain_tdo = '1; scanpath_tdo = 1'b0; chain_sel = 4'd5;
      scan_dr(2, 64'b01);
      pair = dr_out[1:0];
      case (em[6:5])
        2'd0: exp_pair = 2'b10;
        2'd1: exp_pair = 2'b01;
        2'd2: exp_pair = 2'b11;
        default: exp_pair = 2'b00;
      endcase
      chk(pair == exp_pair, "R2 R4 routing per code", pair, exp_pair);
      step(TS_IDLE, 0);
      chk(s_rst == em[0], "R10 restart on entry", s_rst, em[0]);
      step(TS_IDLE, 0);
      chk(s_rst == 1'b0, "R10 no repeat in idle", s_rst, 0);
    end

    // R10: re-entry gives a new pulse
    load_ir(I_RESUME);
    step(TS_IDLE, 0);
    chk(s_rst == 1, "R10 pulse first", s_rst, 1);
    step(TS_SEL_DR, 0);
    step(TS_IDLE, 0);
    chk(s_rst == 1, "R10 pulse on re-entry", s_rst, 1);

    // R4: bypass delay with two patterns
    load_ir(I_BYPASS);
    scan_dr(8, 64'hB4);
    chk(dr_out[7:0] == 8'h68, "R4 bypass B4", dr_out[7:0], 8'h68);
    scan_dr(8, 64'h5B);
    chk(dr_out[7:0] == 8'hB6, "R4 bypass 5B", dr_out[7:0], 8'hB6);

    // R6: chain sweep under EXTEST
    load_ir(I_EXTEST);
    for (int s = 0; s < NCH; s++) begin
      for (int p = 0; p < 2; p++) begin
        chain_sel = s[SEL_W-1:0];
        chain_tdo = (p == 0) ? (NCH'(1) << s) : ~(NCH'(1) << s);
        scan_dr(1, 0);
        chk(dr_out[0] == (p == 0), "R6 chain routing", dr_out[0], (p == 0));
      end
    end
    load_ir(I_INTEST);
    chain_sel = 4'd9; chain_tdo = 16'h0200;
    scan_dr(1, 0);
    chk(dr_out[0] == 1 && test_mode_o == 1, "R6 intest", {test_mode_o, dr_out[0]}, 2'b11);

    // R7: scan-path register
    load_ir(I_SELCHAIN);
    scanpath_tdo = 1'b1;
    scan_dr(1, 0);
    chk(dr_out[0] == 1, "R7 scanpath high", dr_out[0], 1);
    scanpath_tdo = 1'b0;
    scan_dr(1, 0);
    chk(dr_out[0] == 0, "R7 scanpath low", dr_out[0], 0);

    // R3: no effect before Update-IR; Test-Logic-Reset loads IDCODE
    load_ir(I_HIGHZ);
    step(TS_SEL_DR, 0);
    step(TS_SEL_IR, 0);
    step(TS_CAPTURE_IR, 0);
    for (int i = 0; i < 4; i++) step(TS_SHIFT_IR, I_CLAMP[i]);
    step(TS_EXIT1_IR, 0);
    chk(float_bus_o == 1 && clamp_o == 0, "R3 hold before update", {float_bus_o, clamp_o}, 2'b10);
    step(TS_PAUSE_IR, 0);
    step(TS_RESET, 0);
    chk(float_bus_o == 0 && clamp_o == 0, "R3 reset state to IDCODE", {float_bus_o, clamp_o}, 0);
    step(TS_IDLE, 0);
    scan_dr(32, 0);
    chk(dr_out[31:0] == IDV, "R3 R5 ID after TLR", dr_out[31:0], IDV);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule